// File: doc/BRIEF.md
# PLL Bring-Up Sequencer

This block is a hardware state machine that powers up a clock-multiplier PLL. The PLL is controlled through two 32-bit control words, called word 0 and word 1. When the upstream main clock reports that it is ready, a start pulse makes the sequencer take the multiplier and divider values. It then walks a fixed list of register updates. First it enables saturation. Next it enters bypass and asserts the PLL reset. It then loads the divider fields and writes a loop-bandwidth value that it derives from the multiplier. After that it holds reset for a timed interval, releases it, waits a lock interval that grows with the divider, and finally leaves bypass.

Every update is a read-modify-write over a plain register port, so bits outside the target field keep the values that were read. The port has a read strobe, a write strobe, a select line and separate read and write data buses. It carries one transaction at a time and has no back-pressure. Read data is valid in the cycle after the read strobe. The sequencer never issues a new strobe until its current transaction is complete. The `start`, `main_ready`, `busy` and `done` pins are plain level and pulse signals, not a stream handshake.

Top module: `pll_bringup_seq`

## Requirements
- R1: A start pulse is accepted only while the sequencer is idle and `main_ready` is high. If the start is not accepted, `busy` stays low and no register strobe is issued.
- R2: After reset, `busy`, `done`, `reg_rd` and `reg_wr` are low. `busy` rises in the cycle after an accepted start and stays high through the last write. `done` is high for exactly one cycle, in the cycle after the last write, and `busy` is low in that cycle.
- R3: There are eight writes, in this fixed order, with `reg_sel` 0 selecting word 0 and 1 selecting word 1:
  1. word 1 bit 6 set to 1 (saturation enable);
  2. word 0 bypass bit set to 1;
  3. word 1 bit 13 set to 1 (PLL reset asserted);
  4. word 0 multiplier and divider fields;
  5. word 0 bandwidth low byte;
  6. word 1 bandwidth high nibble;
  7. word 1 bit 13 cleared to 0 (reset released);
  8. word 0 bypass bit cleared to 0.
- R4: With the default parameters, word 0 holds the divider in bits [5:0], the multiplier in bits [18:6], bypass in bit 23 and the bandwidth low byte in bits [31:24].
- R5: The 12-bit bandwidth value is ((PLLM + 1) >> 1) - 1, computed in 14-bit arithmetic and truncated to 12 bits. Its bits [7:0] go to word 0 and its bits [11:8] go to word 1 bits [3:0].
- R6: Each write is preceded, two cycles earlier, by a read strobe with the same `reg_sel`. Every write changes only its target field, and all other bits equal the data returned by that read.
- R7: At least ceil(REF_KHZ × HOLD_NS / 10^6) cycles pass between the bandwidth high-nibble write and the reset-release write. With the defaults this is 500 cycles.
- R8: At least LOCK_BASE × (PLLD + 1) cycles pass between the reset-release write and the bypass-clear write. With the defaults LOCK_BASE is 500.
- R9: The multiplier and divider are captured when the start is accepted. A start pulse that arrives while busy changes neither the written values nor the number of runs.
- R10: A synchronous reset in the middle of a run returns the sequencer to idle with `busy` low and issues no further strobes. It leaves the register contents alone. A later start then runs the full sequence, with freshly cleared wait timing.
- R11: `reg_rd` and `reg_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to run the bring-up |
| main_ready | input | 1 | Upstream main clock is set up |
| pllm | input | 13 | Multiplier value |
| plld | input | 6 | Divider value |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| reg_rd | output | 1 | Register read strobe |
| reg_wr | output | 1 | Register write strobe |
| reg_sel | output | 1 | Register select: 0 is word 0, 1 is word 1 |
| reg_wdata | output | 32 | Write data |
| reg_rdata | input | 32 | Read data, valid in the cycle after `reg_rd` |

## Verification
Some rules are checked on every cycle:
- Strobe exclusivity.
- The read-then-write spacing and the matching select.
- Preservation of the reserved bits in word 1.
- Silence on the port while idle.
- Gating of start by `main_ready`.
- The single-cycle `done` pulse.

Other behaviour is shown only by the bench's scenarios against a register model seeded with nonzero reserved contents. This covers the exact order and contents of the eight writes, the bandwidth arithmetic at odd, even and maximum multipliers, the minimum hold and lock spans, whether a start during a run is ignored, and whether a mid-run reset is clean.

// File: rtl/pll_bringup_pkg.sv
package pll_bringup_pkg;

  localparam int REG_W = 32;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ENSAT,
    ST_BYP_ON,
    ST_RST_ON,
    ST_DIV,
    ST_BW_LO,
    ST_BW_HI,
    ST_HOLD,
    ST_RST_OFF,
    ST_LOCK,
    ST_BYP_OFF
  } seq_state_e;

  typedef enum logic [1:0] {
    RMW_IDLE,
    RMW_READ,
    RMW_MERGE,
    RMW_WRITE
  } rmw_state_e;

  typedef struct packed {
    logic             sel;
    logic [REG_W-1:0] mask;
    logic [REG_W-1:0] value;
  } rmw_req_t;

endpackage

// File: rtl/pll_bw_calc.sv
module pll_bw_calc #(
  parameter int M_W  = 13,
  parameter int BW_W = 12
) (
  input  logic [M_W-1:0]  mult,
  output logic [BW_W-1:0] bw
);
  localparam int EXT_W = M_W + 1;

  // half of (mult + 1), minus one; extended by one bit so mult = max does not wrap
  assign bw = BW_W'((({1'b0, mult} + EXT_W'(1)) >> 1) - EXT_W'(1));

endmodule

// File: rtl/pll_wait_timer.sv
module pll_wait_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else             cnt_q <= cnt_q + CNT_W'(1);
  end

  // expires on the last of 'limit' running cycles
  assign expired = run && (cnt_q == limit - CNT_W'(1));

endmodule

// File: rtl/pll_rmw_engine.sv
module pll_rmw_engine
  import pll_bringup_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  rmw_req_t         req_info,
  output logic             ack,
  output logic             reg_rd,
  output logic             reg_wr,
  output logic             reg_sel,
  output logic [REG_W-1:0] reg_wdata,
  input  logic [REG_W-1:0] reg_rdata
);
  rmw_state_e       st_q;
  rmw_req_t         held_q;
  logic [REG_W-1:0] merged_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= RMW_IDLE;
      held_q   <= '0;
      merged_q <= '0;
    end else begin
      unique case (st_q)
        RMW_IDLE: if (req) begin
          held_q <= req_info;
          st_q   <= RMW_READ;
        end
        RMW_READ:  st_q <= RMW_MERGE;
        RMW_MERGE: begin
          merged_q <= (reg_rdata & ~held_q.mask) | (held_q.value & held_q.mask);
          st_q     <= RMW_WRITE;
        end
        RMW_WRITE: st_q <= RMW_IDLE;
        default:   st_q <= RMW_IDLE;
      endcase
    end
  end

  assign reg_rd    = (st_q == RMW_READ);
  assign reg_wr    = (st_q == RMW_WRITE);
  assign ack       = reg_wr;
  assign reg_sel   = held_q.sel;
  assign reg_wdata = merged_q;

endmodule

// File: rtl/pll_bringup_seq.sv
module pll_bringup_seq
  import pll_bringup_pkg::*;
#(
  parameter int REF_KHZ   = 100000,
  parameter int HOLD_NS   = 5000,
  parameter int LOCK_BASE = 500,
  parameter int M_W       = 13,
  parameter int D_W       = 6,
  parameter int BW_W      = 12,
  parameter int D_POS     = 0,
  parameter int M_POS     = 6,
  parameter int BYP_POS   = 23,
  parameter int BWLO_POS  = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             main_ready,
  input  logic [M_W-1:0]   pllm,
  input  logic [D_W-1:0]   plld,
  output logic             busy,
  output logic             done,
  output logic             reg_rd,
  output logic             reg_wr,
  output logic             reg_sel,
  output logic [REG_W-1:0] reg_wdata,
  input  logic [REG_W-1:0] reg_rdata
);
  // word 1 field positions are fixed
  localparam int RST_POS  = 13;
  localparam int SAT_POS  = 6;
  localparam int BWHI_POS = 0;
  localparam int BWLO_W   = 8;
  localparam int BWHI_W   = BW_W - BWLO_W;

  localparam int HOLD_RAW = (REF_KHZ * HOLD_NS + 999999) / 1000000;
  localparam int HOLD_CYC = (HOLD_RAW < 1) ? 1 : HOLD_RAW;
  localparam int LOCK_MAX = LOCK_BASE * (2 ** D_W);
  localparam int CNT_MAX  = (HOLD_CYC > LOCK_MAX) ? HOLD_CYC : LOCK_MAX;
  localparam int CNT_W    = $clog2(CNT_MAX + 1);

  localparam logic [REG_W-1:0] M_MASK    = REG_W'((64'd1 << M_W) - 64'd1) << M_POS;
  localparam logic [REG_W-1:0] D_MASK    = REG_W'((64'd1 << D_W) - 64'd1) << D_POS;
  localparam logic [REG_W-1:0] BYP_MASK  = REG_W'(1) << BYP_POS;
  localparam logic [REG_W-1:0] BWLO_MASK = REG_W'((64'd1 << BWLO_W) - 64'd1) << BWLO_POS;
  localparam logic [REG_W-1:0] RST_MASK  = REG_W'(1) << RST_POS;
  localparam logic [REG_W-1:0] SAT_MASK  = REG_W'(1) << SAT_POS;
  localparam logic [REG_W-1:0] BWHI_MASK = REG_W'((64'd1 << BWHI_W) - 64'd1) << BWHI_POS;

  seq_state_e     st_q, st_d;
  logic [M_W-1:0] m_q;
  logic [D_W-1:0] d_q;
  logic [BW_W-1:0] bw;
  logic           done_q;
  logic           req, ack;
  rmw_req_t       op;
  logic           t_run, t_exp;
  logic [CNT_W-1:0] t_limit;

  pll_bw_calc #(.M_W(M_W), .BW_W(BW_W)) u_bw (
    .mult (m_q),
    .bw   (bw)
  );

  pll_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .run     (t_run),
    .limit   (t_limit),
    .expired (t_exp)
  );

  pll_rmw_engine u_rmw (
    .clk       (clk),
    .rst       (rst),
    .req       (req),
    .req_info  (op),
    .ack       (ack),
    .reg_rd    (reg_rd),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata)
  );

  // field update requested by each write step
  always_comb begin
    req = 1'b1;
    op  = '0;
    unique case (st_q)
      ST_ENSAT:   op = '{sel: 1'b1, mask: SAT_MASK, value: SAT_MASK};
      ST_BYP_ON:  op = '{sel: 1'b0, mask: BYP_MASK, value: BYP_MASK};
      ST_RST_ON:  op = '{sel: 1'b1, mask: RST_MASK, value: RST_MASK};
      ST_DIV:     op = '{sel: 1'b0, mask: M_MASK | D_MASK,
                         value: (REG_W'(m_q) << M_POS) | (REG_W'(d_q) << D_POS)};
      ST_BW_LO:   op = '{sel: 1'b0, mask: BWLO_MASK,
                         value: REG_W'(bw[BWLO_W-1:0]) << BWLO_POS};
      ST_BW_HI:   op = '{sel: 1'b1, mask: BWHI_MASK,
                         value: REG_W'(bw[BW_W-1:BWLO_W]) << BWHI_POS};
      ST_RST_OFF: op = '{sel: 1'b1, mask: RST_MASK, value: '0};
      ST_BYP_OFF: op = '{sel: 1'b0, mask: BYP_MASK, value: '0};
      default:    req = 1'b0;
    endcase
  end

  assign t_run   = (st_q == ST_HOLD) || (st_q == ST_LOCK);
  assign t_limit = (st_q == ST_HOLD) ? CNT_W'(HOLD_CYC)
                                     : CNT_W'(LOCK_BASE) * (CNT_W'(d_q) + CNT_W'(1));

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:    if (start && main_ready) st_d = ST_ENSAT;
      ST_ENSAT:   if (ack) st_d = ST_BYP_ON;
      ST_BYP_ON:  if (ack) st_d = ST_RST_ON;
      ST_RST_ON:  if (ack) st_d = ST_DIV;
      ST_DIV:     if (ack) st_d = ST_BW_LO;
      ST_BW_LO:   if (ack) st_d = ST_BW_HI;
      ST_BW_HI:   if (ack) st_d = ST_HOLD;
      ST_HOLD:    if (t_exp) st_d = ST_RST_OFF;
      ST_RST_OFF: if (ack) st_d = ST_LOCK;
      ST_LOCK:    if (t_exp) st_d = ST_BYP_OFF;
      ST_BYP_OFF: if (ack) st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      m_q    <= '0;
      d_q    <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= (st_q == ST_BYP_OFF) && ack;
      if (st_q == ST_IDLE && start && main_ready) begin
        m_q <= pllm;
        d_q <= plld;
      end
    end
  end

  assign busy = (st_q != ST_IDLE);
  assign done = done_q;

endmodule

// File: rtl/pll_bringup_chk.sv
module pll_bringup_chk (
  input logic        clk,
  input logic        rst,
  input logic        start,
  input logic        main_ready,
  input logic        busy,
  input logic        done,
  input logic        reg_rd,
  input logic        reg_wr,
  input logic        reg_sel,
  input logic [31:0] reg_wdata,
  input logic [31:0] reg_rdata
);
  // bits of word 1 that no step may alter
  localparam logic [31:0] W1_KEEP = ~32'h0000_204F;

  // R11
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !(reg_rd && reg_wr));

  // R6
  rmw_order_chk: assert property (@(posedge clk) disable iff (rst)
    reg_wr |-> ($past(reg_rd, 2) && ($past(reg_sel, 2) == reg_sel)));

  // R6
  w1_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_sel) |-> (((reg_wdata ^ $past(reg_rdata)) & W1_KEEP) == 32'h0));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!reg_rd && !reg_wr));

  // R1
  start_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start && main_ready));

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R2
  done_end_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy) && $past(reg_wr)));

endmodule

bind pll_bringup_seq pll_bringup_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .main_ready (main_ready),
  .busy       (busy),
  .done       (done),
  .reg_rd     (reg_rd),
  .reg_wr     (reg_wr),
  .reg_sel    (reg_sel),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata)
);

// File: tb/pll_bringup_seq_bench.sv
module pll_bringup_seq_bench;
  localparam int HOLD = 500;
  localparam int LOCKB = 500;
  localparam logic [31:0] D_MSK = 32'h0000_003F, M_MSK = 32'h0007_FFC0;
  localparam logic [31:0] BYP = 32'h0080_0000, BWLO = 32'hFF00_0000;
  localparam logic [31:0] RSTB = 32'h0000_2000, SAT = 32'h0000_0040, BWHI = 32'h0000_000F;

  logic clk = 0, rst = 1, start = 0, main_ready = 0;
  logic [12:0] pllm = '0;
  logic [5:0]  plld = '0;
  logic busy, done, reg_rd, reg_wr, reg_sel;
  logic [31:0] reg_wdata, reg_rdata = '0;

  pll_bringup_seq u_pll_bringup_seq (
    .clk(clk), .rst(rst), .start(start), .main_ready(main_ready),
    .pllm(pllm), .plld(plld), .busy(busy), .done(done),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  always #10 clk = ~clk;

  // register model: plain storage, read data one cycle after strobe
  logic [31:0] regs [2];
  initial begin regs[0] = 32'h5A3C_96E1; regs[1] = 32'hC3A5_9E1B; end
  always @(posedge clk) begin
    if (reg_rd) reg_rdata <= regs[reg_sel];
    if (reg_wr) regs[reg_sel] <= reg_wdata;
  end

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  typedef struct { logic sel; logic [31:0] data; string tag; int step; } item_t;
  item_t q[$];
  logic [31:0] exp_reg [2];
  int push_idx;
  int wcyc [8];

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] m, input logic [31:0] v);
    return (o & ~m) | (v & m);
  endfunction

  task automatic push(input logic s, input logic [31:0] m, input logic [31:0] v, input string tag);
    item_t it;
    exp_reg[s] = merge(exp_reg[s], m, v);
    it.sel = s; it.data = exp_reg[s]; it.tag = tag; it.step = push_idx;
    q.push_back(it);
    push_idx++;
  endtask

  // driver side of the scoreboard: expected eight writes
  task automatic expect_seq(input logic [12:0] m, input logic [5:0] d);
    logic [13:0] t;
    logic [11:0] bw;
    t = ((({1'b0, m}) + 14'd1) >> 1) - 14'd1;
    bw = t[11:0];
    push_idx = 0;
    push(1'b1, SAT, SAT, "R3 ensat");
    push(1'b0, BYP, BYP, "R3/R4 bypass on");
    push(1'b1, RSTB, RSTB, "R3 reset on");
    push(1'b0, M_MSK | D_MSK, (32'(m) << 6) | 32'(d), "R4 dividers");
    push(1'b0, BWLO, 32'(bw[7:0]) << 24, "R5 bw low");
    push(1'b1, BWHI, 32'(bw[11:8]), "R5 bw high");
    push(1'b1, RSTB, 32'h0, "R3 reset off");
    push(1'b0, BYP, 32'h0, "R3/R4 bypass off");
  endtask

  // monitor side of the scoreboard
  logic rd_d1 = 0, rd_d2 = 0, sel_d1 = 0, sel_d2 = 0;
  always @(negedge clk) begin
    if (reg_rd && reg_wr) check(0, "R11 strobes together", 32'h1, 32'h0);
    if (reg_wr) begin
      check(rd_d2 && sel_d2 == reg_sel, "R6 read two cycles before write", {31'b0, rd_d2}, 32'h1);
      if (q.size() == 0) check(0, "R1/R10 unexpected write", reg_wdata, 32'h0);
      else begin
        item_t it;
        it = q.pop_front();
        check(reg_sel == it.sel, {it.tag, " select"}, {31'b0, reg_sel}, {31'b0, it.sel});
        check(reg_wdata == it.data, it.tag, reg_wdata, it.data);
        wcyc[it.step] = cyc;
      end
    end
    rd_d2 <= rd_d1; rd_d1 <= reg_rd;
    sel_d2 <= sel_d1; sel_d1 <= reg_sel;
  end

  task automatic kick(input logic [12:0] m, input logic [5:0] d);
    @(negedge clk); pllm = m; plld = d; start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_done(input int d);
    int n = 0;
    while (!done && n < 40000) begin @(negedge clk); n++; end
    check(done == 1'b1, "R2 done seen", {31'b0, done}, 32'h1);
    check(busy == 1'b0, "R2 busy low with done", {31'b0, busy}, 32'h0);
    @(negedge clk);
    check(done == 1'b0, "R2 done one cycle", {31'b0, done}, 32'h0);
    check(q.size() == 0, "R3 all writes seen", q.size(), 32'h0);
    check(wcyc[6] - wcyc[5] >= HOLD && wcyc[6] - wcyc[5] <= HOLD + 8,
          "R7 reset hold span", wcyc[6] - wcyc[5], HOLD);
    check(wcyc[7] - wcyc[6] >= LOCKB * (d + 1) && wcyc[7] - wcyc[6] <= LOCKB * (d + 1) + 8,
          "R8 lock wait span", wcyc[7] - wcyc[6], LOCKB * (d + 1));
  endtask

  task automatic full_run(input logic [12:0] m, input logic [5:0] d);
    expect_seq(m, d);
    kick(m, d);
    check(busy == 1'b1, "R2 busy after start", {31'b0, busy}, 32'h1);
    wait_done(d);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check(0, "watchdog expired", 32'h0, 32'h1);
    summary();
  end

  initial begin
    exp_reg[0] = regs[0]; exp_reg[1] = regs[1];
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R2 reset state
    check(!busy && !done && !reg_rd && !reg_wr, "R2 reset state",
          {28'b0, busy, done, reg_rd, reg_wr}, 32'h0);

    // R1: start without main_ready is ignored
    begin
      bit seen = 0;
      kick(13'd15, 6'd0);
      repeat (20) begin @(negedge clk); if (busy || reg_rd) seen = 1; end
      check(!seen, "R1 start gated by main_ready", {31'b0, seen}, 32'h0);
    end

    main_ready = 1;
    full_run(13'd15, 6'd0);          // odd multiplier: bw 7

    // R9: start during run ignored
    expect_seq(13'd16, 6'd3);
    kick(13'd16, 6'd3);
    repeat (40) @(negedge clk);
    pllm = 13'd999; plld = 6'd5; start = 1;
    @(negedge clk); start = 0;
    wait_done(3);
    repeat (30) @(negedge clk);
    check(!busy, "R9 no second run", {31'b0, busy}, 32'h0);

    full_run(13'd8191, 6'd63);        // maximum multiplier and divider

    // R10: reset during hold
    begin
      logic [31:0] s0, s1;
      bit seen = 0;
      expect_seq(13'd100, 6'd1);
      kick(13'd100, 6'd1);
      while (q.size() > 2) @(negedge clk);
      repeat (20) @(negedge clk);
      s0 = regs[0]; s1 = regs[1];
      rst = 1; repeat (3) @(negedge clk); rst = 0;
      q.delete();
      repeat (60) begin @(negedge clk); if (busy || reg_rd || reg_wr) seen = 1; end
      check(!seen, "R10 idle after reset", {31'b0, seen}, 32'h0);
      check(regs[0] == s0, "R10 word 0 untouched", regs[0], s0);
      check(regs[1] == s1, "R10 word 1 untouched", regs[1], s1);
      exp_reg[0] = regs[0]; exp_reg[1] = regs[1];
    end
    full_run(13'd33, 6'd2);
    summary();
  end
endmodule